// File: doc/BRIEF.md
# Multi-Seed LFSR Test Pattern Source

This block feeds a circuit under test with one new input vector on every clock, for built-in self-test where patterns go in parallel rather than through a scan chain. The pattern register is a linear feedback shift register (LFSR) as wide as the circuit's input bus, and each register state is presented as one test vector.

A short constant table holds several seeds, each with its own run length. A start pulse loads the first seed, which becomes the first vector. The register then steps once per clock until that seed's run length is used up. On the very next cycle the following seed is presented, with no gap between runs. The total vector count is the sum of the run lengths. After the last vector of the last seed, the block raises a done flag and freezes its output until it is started again. The seed table, the run lengths and the feedback tap mask are all parameters. The table is expected to be sorted by ascending run length, because that is the order in which the seeds are applied.

Top module: `reseed_pattern_gen`

## Requirements
- R1: After reset, the pattern output is all zeros and both the valid strobe and the done flag are low.
- R2: On the cycle after the clock edge that samples start high, the pattern output equals seed 0 and the valid strobe is high.
- R3: While a seed's run continues, each new pattern is the previous one shifted up by one bit. Bit 0 takes the XOR of the previous bits selected by the tap mask. The default 5-bit mask selects bits 1 and 4, which gives the polynomial 1 + x^2 + x^5.
- R4: Each seed is applied for exactly its run length in valid cycles. The next seed appears on the cycle right after the previous seed's last pattern, with no idle cycle.
- R5: A seed whose run length is 1 contributes only its seed pattern.
- R6: Seeds are applied in table order, index 0 first. The table is kept in ascending order of run length.
- R7: From one start, the valid strobe is high for exactly the sum of all run lengths. After that, done is high and valid is low.
- R8: While done is high and start is low, clocks leave the pattern and the done flag unchanged.
- R9: A start pulse during a run, or after done, restarts the sequence from seed 0 and clears done.
- R10: A zero run length is not permitted. The remaining-run counter is never zero while valid is high.
- R11: The valid strobe and the done flag are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin (or restart) the seed sequence |
| pattern | output | WIDTH | Test vector for the circuit under test |
| patternValid | output | 1 | High on every cycle a vector is applied |
| done | output | 1 | High once the last seed's run has finished |

## Verification
Every result is due one clock after its cause: the first seed follows the start edge by one cycle, each shifted vector or seed switch follows the previous vector by one cycle, and done follows the final vector by one cycle. The bench drives start just after a rising edge and samples all outputs one nanosecond after the next rising edge. At that point it has advanced its own cycle model by exactly one step, so each comparison lines up with the register that produced it. Directed runs additionally pin the seed boundaries, the single-cycle seed and the total vector count.

// File: rtl/reseed_pkg.sv
package reseed_pkg;
  localparam int SEL_W = 8;

  typedef struct packed {
    logic             loadSeed;
    logic             stepLfsr;
    logic [SEL_W-1:0] seedSel;
  } reseed_ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } reseed_state_e;
endpackage

// File: rtl/reseed_ctrl.sv
module reseed_ctrl
  import reseed_pkg::*;
#(
  parameter int NUM_SEEDS = 4,
  parameter int LEN_W = 8,
  parameter logic [NUM_SEEDS*LEN_W-1:0] RUN_LENS = {8'd20, 8'd6, 8'd3, 8'd1}
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output reseed_ctrl_t     ctrl,
  output logic             patternValid,
  output logic             done,
  output logic [LEN_W-1:0] runLeft
);
  localparam int IDX_W = (NUM_SEEDS > 1) ? $clog2(NUM_SEEDS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SEEDS - 1);

  logic [LEN_W-1:0] lenTab [NUM_SEEDS];
  for (genvar g = 0; g < NUM_SEEDS; g++) begin : gLen
    assign lenTab[g] = RUN_LENS[g*LEN_W +: LEN_W];
  end

  reseed_state_e    state;
  logic [IDX_W-1:0] seedIdx;
  logic [IDX_W-1:0] nextIdx;
  logic             running;
  logic             runEnds;
  logic             lastSeed;

  assign nextIdx  = seedIdx + 1'b1;
  assign running  = (state == ST_RUN);
  assign runEnds  = running && (runLeft == LEN_W'(1));
  assign lastSeed = (seedIdx == LAST_IDX);

  always_comb begin
    ctrl.loadSeed = start || (runEnds && !lastSeed);
    ctrl.stepLfsr = !start && running && (runLeft > LEN_W'(1));
    ctrl.seedSel  = start ? '0 : SEL_W'(nextIdx);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      seedIdx <= '0;
      runLeft <= '0;
    end else if (start) begin
      state   <= ST_RUN;
      seedIdx <= '0;
      runLeft <= lenTab[0];
    end else if (running) begin
      if (runEnds) begin
        if (lastSeed) begin
          state   <= ST_DONE;
          runLeft <= '0;
        end else begin
          seedIdx <= nextIdx;
          runLeft <= lenTab[nextIdx];
        end
      end else begin
        runLeft <= runLeft - 1'b1;
      end
    end
  end

  assign patternValid = (state == ST_RUN);
  assign done         = (state == ST_DONE);
endmodule

// File: rtl/reseed_datapath.sv
module reseed_datapath
  import reseed_pkg::*;
#(
  parameter int WIDTH = 5,
  parameter int NUM_SEEDS = 4,
  parameter logic [NUM_SEEDS*WIDTH-1:0] SEEDS = {5'h1F, 5'h12, 5'h01, 5'h1D},
  parameter logic [WIDTH-1:0] TAPS = 5'b10010
) (
  input  logic             clk,
  input  logic             rstN,
  input  reseed_ctrl_t     ctrl,
  output logic [WIDTH-1:0] pattern
);
  localparam int IDX_W = (NUM_SEEDS > 1) ? $clog2(NUM_SEEDS) : 1;

  logic [WIDTH-1:0] seedTab [NUM_SEEDS];
  for (genvar g = 0; g < NUM_SEEDS; g++) begin : gSeed
    assign seedTab[g] = SEEDS[g*WIDTH +: WIDTH];
  end

  logic [WIDTH-1:0] tapped;
  logic             feedback;
  logic [WIDTH-1:0] shifted;

  assign tapped   = pattern & TAPS;
  assign feedback = ^tapped;
  assign shifted  = {pattern[WIDTH-2:0], feedback};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pattern <= '0;
    end else if (ctrl.loadSeed) begin
      pattern <= seedTab[ctrl.seedSel[IDX_W-1:0]];
    end else if (ctrl.stepLfsr) begin
      pattern <= shifted;
    end
  end
endmodule

// File: rtl/reseed_pattern_gen.sv
module reseed_pattern_gen
  import reseed_pkg::*;
#(
  parameter int WIDTH = 5,
  parameter int NUM_SEEDS = 4,
  parameter int LEN_W = 8,
  parameter logic [NUM_SEEDS*WIDTH-1:0] SEEDS = {5'h1F, 5'h12, 5'h01, 5'h1D},
  parameter logic [NUM_SEEDS*LEN_W-1:0] RUN_LENS = {8'd20, 8'd6, 8'd3, 8'd1},
  parameter logic [WIDTH-1:0] TAPS = 5'b10010
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output logic [WIDTH-1:0] pattern,
  output logic             patternValid,
  output logic             done
);
  reseed_ctrl_t     ctrlBus;
  logic [LEN_W-1:0] runLeft;

  reseed_ctrl #(
    .NUM_SEEDS(NUM_SEEDS),
    .LEN_W(LEN_W),
    .RUN_LENS(RUN_LENS)
  ) uCtrl (
    .clk(clk),
    .rstN(rstN),
    .start(start),
    .ctrl(ctrlBus),
    .patternValid(patternValid),
    .done(done),
    .runLeft(runLeft)
  );

  reseed_datapath #(
    .WIDTH(WIDTH),
    .NUM_SEEDS(NUM_SEEDS),
    .SEEDS(SEEDS),
    .TAPS(TAPS)
  ) uData (
    .clk(clk),
    .rstN(rstN),
    .ctrl(ctrlBus),
    .pattern(pattern)
  );
endmodule

// File: rtl/reseed_pattern_gen_chk.sv
module reseed_pattern_gen_chk #(
  parameter int WIDTH = 5,
  parameter int NUM_SEEDS = 4,
  parameter int LEN_W = 8,
  parameter logic [NUM_SEEDS*WIDTH-1:0] SEEDS = {5'h1F, 5'h12, 5'h01, 5'h1D}
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [WIDTH-1:0] pattern,
  input logic             patternValid,
  input logic             done,
  input logic [LEN_W-1:0] runLeft
);
  // R2: the first seed appears right after start
  a_r2_first_seed: assert property (@(posedge clk) disable iff (!rstN)
    start |=> patternValid && (pattern == SEEDS[WIDTH-1:0]));

  // R3: within a run the upper bits are the previous lower bits
  a_r3_shift: assert property (@(posedge clk) disable iff (!rstN)
    (patternValid && !start && runLeft > LEN_W'(1))
      |=> pattern[WIDTH-1:1] == $past(pattern[WIDTH-2:0]));

  // R7: valid only ends into done (unless restarted)
  a_r7_done_follows: assert property (@(posedge clk) disable iff (!rstN)
    (patternValid && !start && runLeft == LEN_W'(1)) |=> (done || patternValid));

  // R8: done state holds its pattern
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done && $stable(pattern));

  // R10: run counter never zero while a pattern is applied
  a_r10_len_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    patternValid |-> runLeft != '0);

  // R11: valid and done exclusive
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(patternValid && done));
endmodule

bind reseed_pattern_gen reseed_pattern_gen_chk #(
  .WIDTH(WIDTH),
  .NUM_SEEDS(NUM_SEEDS),
  .LEN_W(LEN_W),
  .SEEDS(SEEDS)
) uChk (
  .clk(clk),
  .rstN(rstN),
  .start(start),
  .pattern(pattern),
  .patternValid(patternValid),
  .done(done),
  .runLeft(runLeft)
);

// File: tb/reseed_pattern_gen_test.sv
`timescale 1ns/1ps
module reseed_pattern_gen_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [4:0] pattern;
  logic       patternValid;
  logic       done;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  reseed_pattern_gen uut (
    .clk(clk), .rstN(rstN), .start(start),
    .pattern(pattern), .patternValid(patternValid), .done(done)
  );

  // Bench-side seed table and rule, from the requirements
  function automatic logic [4:0] seedOf(input int i);
    case (i)
      0: return 5'h1D;
      1: return 5'h01;
      2: return 5'h12;
      default: return 5'h1F;
    endcase
  endfunction

  function automatic int lenOf(input int i);
    case (i)
      0: return 1;
      1: return 3;
      2: return 6;
      default: return 20;
    endcase
  endfunction

  function automatic logic [4:0] stepOf(input logic [4:0] p);
    return {p[3:0], p[1] ^ p[4]};
  endfunction

  // Model state
  int         mState = 0;  // 0 idle, 1 run, 2 done
  int         mIdx = 0;
  int         mLeft = 0;
  logic [4:0] mPat = '0;
  string      mTag = "R1";

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic modelStep(input logic st);
    if (st) begin
      mState = 1; mIdx = 0; mLeft = lenOf(0); mPat = seedOf(0); mTag = "R2";
    end else if (mState == 1) begin
      if (mLeft == 1) begin
        if (mIdx == 3) begin
          mState = 2; mTag = "R8";
        end else begin
          mIdx++; mLeft = lenOf(mIdx); mPat = seedOf(mIdx); mTag = "R4";
        end
      end else begin
        mLeft--; mPat = stepOf(mPat); mTag = "R3";
      end
    end else if (mState == 2) begin
      mTag = "R8";
    end
  endtask

  task automatic cycle(input logic st);
    start = st;
    @(posedge clk);
    #1;
    modelStep(st);
    start = 1'b0;
    chk(pattern == mPat, mTag, "pattern", int'(pattern), int'(mPat));
    chk(patternValid == (mState == 1), "R7", "valid", int'(patternValid), int'(mState == 1));
    chk(done == (mState == 2), "R7", "done", int'(done), int'(mState == 2));
    chk(!(patternValid && done), "R11", "valid&done", int'(patternValid && done), 0);
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [4:0] got [30];
    int nValid;
    void'($urandom(32'h5EED1234));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(pattern == 5'h0, "R1", "reset pattern", int'(pattern), 0);
    chk(!patternValid && !done, "R1", "reset flags", int'({patternValid, done}), 0);
    rstN = 1'b1;
    cycle(1'b0);

    // Directed full run: R2 R4 R5 R6 R7
    nValid = 0;
    cycle(1'b1);
    for (int k = 0; k < 40; k++) begin
      if (patternValid && nValid < 30) got[nValid] = pattern;
      if (patternValid) nValid++;
      cycle(1'b0);
    end
    chk(got[0] == seedOf(0), "R2", "first vector", int'(got[0]), int'(seedOf(0)));
    chk(got[1] == seedOf(1), "R5", "length-1 seed followed directly", int'(got[1]), int'(seedOf(1)));
    chk(got[2] == stepOf(seedOf(1)), "R3", "first step", int'(got[2]), int'(stepOf(seedOf(1))));
    chk(got[4] == seedOf(2), "R6", "third seed position", int'(got[4]), int'(seedOf(2)));
    chk(got[10] == seedOf(3), "R6", "fourth seed position", int'(got[10]), int'(seedOf(3)));
    chk(nValid == 30, "R7", "total valid cycles", nValid, 30);
    chk(done == 1'b1, "R8", "done held", int'(done), 1);

    // R9: restart mid-run
    cycle(1'b1);
    repeat (7) cycle(1'b0);
    cycle(1'b1);
    chk(pattern == seedOf(0), "R9", "restart vector", int'(pattern), int'(seedOf(0)));
    repeat (35) cycle(1'b0);

    // Random: gaps, restarts and completions
    for (int it = 0; it < 40; it++) begin
      int gap;
      int len;
      gap = int'($urandom_range(0, 5));
      len = int'($urandom_range(1, 40));
      repeat (gap) cycle(1'b0);
      cycle(1'b1);
      repeat (len) cycle(1'b0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule